// File: doc/BRIEF.md
# USB Start-of-Frame Scheduler

This block keeps the one-millisecond frame rhythm of a USB host controller. Software launches a first start-of-frame (SOF) token by hand. From then on the scheduler counts bit-time ticks and raises an SOF request to the packet serializer at each frame boundary. It stops when software clears the running state, when a bus reset is requested, when the port is suspended, or when the device disconnects. After a stop, automatic SOFs start again only when software launches another SOF. The 11-bit frame number advances with every SOF that goes out.

Before each boundary there is a guard window, programmed in bit times. A data token (IN, OUT or SETUP) requested inside this window is held back. It goes out directly after the SOF. Only one data token can wait at a time, and a second request made while one waits is refused. A boundary that arrives while the serializer is still busy with an earlier packet loses its SOF. That loss is recorded in a sticky error flag.

The serializer side uses a request/grant handshake. A launch takes place in the cycle where `txReq` and `txGrant` are both high, and `txIsSof` says which kind of token is being launched. Building the packet and computing the CRC are done elsewhere.

Top module: `sof_frame_sched`

## Requirements
- R1: After reset, `sofBusy`, `txReq`, `lostSof` and `guardActive` are 0 and `txFrame` is 0. A one-cycle `swSofReq` raises `txReq` with `txIsSof`=1. The grant of this manual SOF pulses `launchDone`, sets `sofBusy` on the next edge and advances `txFrame` by one.
- R2: While `sofBusy` is 1, an automatic SOF request is raised every FRAME_BITS `bitTick` pulses, measured from the last manual SOF launch. Cycles without `bitTick` do not advance the frame timer.
- R3: The launch of an automatic SOF never pulses `launchDone`.
- R4: A pulse on any of `swClearBusy`, `busReset`, `suspend` or `disconnect` clears `sofBusy` on the next edge, and no further automatic SOF is launched.
- R5: Once stopped, automatic SOFs stay off until a new `swSofReq` launches a manual SOF. After that, they resume.
- R6: While `sofBusy` is 1, `guardActive` is high exactly while the frame timer has at most `guardBits` bit times left before the boundary tick. This gives (guardBits+1) bit times of guard per frame.
- R7: A `tokReq` outside the guard window raises `txReq` with `txIsSof`=0 in the next cycle. Its grant pulses `launchDone`.
- R8: A `tokReq` made while `guardActive` is high is not launched during the window. It is launched in the cycle right after the SOF grant.
- R9: While a data token waits for launch, a further `tokReq` pulses `tokReject` in the same cycle and is dropped. Only one data launch results.
- R10: If `txBusy` is high at a frame boundary, that boundary's SOF is not requested and `txFrame` is unchanged. `lostSof` is set and stays 1 until an `errClear` pulse.
- R11: `txFrame` is 11 bits wide and wraps from 2047 to 0. A `frameSet` pulse loads `frameSetVal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One pulse per USB bit time |
| guardBits | input | CntW | Guard window length in bit times |
| swSofReq | input | 1 | Software request for a manual SOF |
| swClearBusy | input | 1 | Software stop of automatic SOFs |
| busReset | input | 1 | Bus reset request (stop condition) |
| suspend | input | 1 | Suspend request (stop condition) |
| disconnect | input | 1 | Device connection lost (stop condition) |
| tokReq | input | 1 | Software request for a data token launch |
| tokReject | output | 1 | The current `tokReq` was refused |
| launchDone | output | 1 | A software-requested token is being launched |
| txReq | output | 1 | Launch request to the serializer |
| txIsSof | output | 1 | The request is an SOF (1) or a data token (0) |
| txGrant | input | 1 | Serializer accepts the request |
| txBusy | input | 1 | Serializer is sending a packet |
| txFrame | output | 11 | Current frame number |
| frameSet | input | 1 | Load the frame number |
| frameSetVal | input | 11 | Value loaded by `frameSet` |
| sofBusy | output | 1 | Automatic SOF generation is running |
| guardActive | output | 1 | The guard window is open |
| lostSof | output | 1 | Sticky lost-SOF error |
| errClear | input | 1 | Clears `lostSof` |

## Verification
The automatic SOF stream is exercised with several pairs of guard length and bit-tick rate. This separates a period that follows the tick pulses from one that follows raw clock cycles, and a window of guard+1 bit times from an off-by-one one. The token path is driven in three ways: outside the window, inside it, and twice inside it. These runs tell an immediate launch apart from a deferred one, and a deferred launch that follows the SOF directly from one that is lost or doubled. The four stop sources are each applied in turn, each followed by a long idle stretch and then a relaunch. A serializer that stays busy across a boundary shows that the SOF is dropped and that the error flag holds until it is cleared.

// File: rtl/sof_sched_pkg.sv
package sof_sched_pkg;
  localparam int FrameNumW = 11;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic restart;   // manual SOF launched: reload the frame timer
    logic frameInc;  // any SOF launched: advance frame number
    logic run;       // automatic generation active
  } schedStrobes_t;
endpackage

// File: rtl/sof_sched_dp.sv
module sof_sched_dp
  import sof_sched_pkg::*;
#(
  parameter int FRAME_BITS = 12000,
  localparam int CntW = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic [CntW-1:0]      guardBits,
  input  logic                 frameSet,
  input  logic [FrameNumW-1:0] frameSetVal,
  input  schedStrobes_t        strb,
  output logic                 boundary,
  output logic                 inGuard,
  output logic [FrameNumW-1:0] frameNum
);
  localparam logic [CntW-1:0] LastCnt = CntW'(FRAME_BITS - 1);

  logic [CntW-1:0] bitCnt;  // bit times left before the boundary tick

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= LastCnt;
      frameNum <= '0;
    end else begin
      if (strb.restart || !strb.run) begin
        bitCnt <= LastCnt;
      end else if (bitTick) begin
        bitCnt <= (bitCnt == '0) ? LastCnt : bitCnt - 1'b1;
      end
      if (frameSet) begin
        frameNum <= frameSetVal;
      end else if (strb.frameInc) begin
        frameNum <= frameNum + 1'b1;
      end
    end
  end

  always_comb begin
    boundary = strb.run && !strb.restart && bitTick && (bitCnt == '0);
    inGuard  = strb.run && (bitCnt <= guardBits);
  end
endmodule

// File: rtl/sof_sched_ctl.sv
module sof_sched_ctl
  import sof_sched_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          swSofReq,
  input  logic          swClearBusy,
  input  logic          busReset,
  input  logic          suspend,
  input  logic          disconnect,
  input  logic          tokReq,
  input  logic          txGrant,
  input  logic          txBusy,
  input  logic          errClear,
  input  logic          boundary,
  input  logic          inGuard,
  output schedStrobes_t strb,
  output logic          txReq,
  output logic          txIsSof,
  output logic          launchDone,
  output logic          tokReject,
  output logic          sofBusy,
  output logic          lostSof
);
  logic manPend, autoPend, tokPend;
  logic stopNow, grant, sofGo, tokGo, manGo;

  always_comb begin
    stopNow    = swClearBusy || busReset || suspend || disconnect;
    txIsSof    = manPend || autoPend;
    // SOF always wins; a data token waits out the guard window
    txReq      = txIsSof || (tokPend && !inGuard);
    grant      = txReq && txGrant;
    sofGo      = grant && txIsSof;
    tokGo      = grant && !txIsSof;
    manGo      = sofGo && manPend;
    launchDone = manGo || tokGo;
    tokReject  = tokReq && tokPend;
    strb.restart  = manGo;
    strb.frameInc = sofGo;
    strb.run      = sofBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      manPend  <= 1'b0;
      autoPend <= 1'b0;
      tokPend  <= 1'b0;
      sofBusy  <= 1'b0;
      lostSof  <= 1'b0;
    end else begin
      if (manGo)         manPend <= 1'b0;
      else if (swSofReq) manPend <= 1'b1;

      if (stopNow)    sofBusy <= 1'b0;
      else if (manGo) sofBusy <= 1'b1;

      if (stopNow) begin
        autoPend <= 1'b0;
      end else begin
        if (sofGo && !manPend)     autoPend <= 1'b0;
        if (boundary && !txBusy)   autoPend <= 1'b1;
      end

      if (tokGo)                   tokPend <= 1'b0;
      else if (tokReq && !tokPend) tokPend <= 1'b1;

      if (boundary && txBusy) lostSof <= 1'b1;
      else if (errClear)      lostSof <= 1'b0;
    end
  end
endmodule

// File: rtl/sof_frame_sched.sv
module sof_frame_sched
  import sof_sched_pkg::*;
#(
  parameter int FRAME_BITS = 12000,
  localparam int CntW = $clog2(FRAME_BITS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bitTick,
  input  logic [CntW-1:0]      guardBits,
  input  logic                 swSofReq,
  input  logic                 swClearBusy,
  input  logic                 busReset,
  input  logic                 suspend,
  input  logic                 disconnect,
  input  logic                 tokReq,
  output logic                 tokReject,
  output logic                 launchDone,
  output logic                 txReq,
  output logic                 txIsSof,
  input  logic                 txGrant,
  input  logic                 txBusy,
  output logic [FrameNumW-1:0] txFrame,
  input  logic                 frameSet,
  input  logic [FrameNumW-1:0] frameSetVal,
  output logic                 sofBusy,
  output logic                 guardActive,
  output logic                 lostSof,
  input  logic                 errClear
);
  schedStrobes_t strb;
  logic boundary;

  sof_sched_ctl u_ctl (
    .clk, .rstN, .swSofReq, .swClearBusy, .busReset, .suspend, .disconnect,
    .tokReq, .txGrant, .txBusy, .errClear, .boundary,
    .inGuard(guardActive), .strb, .txReq, .txIsSof, .launchDone, .tokReject,
    .sofBusy, .lostSof
  );

  sof_sched_dp #(.FRAME_BITS(FRAME_BITS)) u_dp (
    .clk, .rstN, .bitTick, .guardBits, .frameSet, .frameSetVal, .strb,
    .boundary, .inGuard(guardActive), .frameNum(txFrame)
  );
endmodule

// File: rtl/sof_sched_chk.sv
module sof_sched_chk
  import sof_sched_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 swClearBusy,
  input logic                 busReset,
  input logic                 suspend,
  input logic                 disconnect,
  input logic                 frameSet,
  input logic                 errClear,
  input logic                 txReq,
  input logic                 txIsSof,
  input logic                 txGrant,
  input logic                 launchDone,
  input logic                 sofBusy,
  input logic                 lostSof,
  input logic                 guardActive,
  input logic [FrameNumW-1:0] txFrame,
  input schedStrobes_t        strb
);
  logic anyStop;
  assign anyStop = swClearBusy || busReset || suspend || disconnect;

  a_r1_busy_after_manual: assert property (@(posedge clk) disable iff (!rstN)
    (strb.restart && !anyStop) |=> sofBusy);

  a_r4_stop_clears_busy: assert property (@(posedge clk) disable iff (!rstN)
    anyStop |=> !sofBusy);

  a_r3_auto_sof_silent: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && txGrant && txIsSof && !strb.restart) |-> !launchDone);

  a_r6_no_guard_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !sofBusy |-> !guardActive);

  a_r10_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lostSof && !errClear) |=> lostSof);

  a_r11_frame_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameInc && !frameSet) |=> (txFrame == $past(txFrame) + 11'd1));
endmodule

bind sof_frame_sched sof_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .swClearBusy(swClearBusy), .busReset(busReset),
  .suspend(suspend), .disconnect(disconnect), .frameSet(frameSet),
  .errClear(errClear), .txReq(txReq), .txIsSof(txIsSof), .txGrant(txGrant),
  .launchDone(launchDone), .sofBusy(sofBusy), .lostSof(lostSof),
  .guardActive(guardActive), .txFrame(txFrame), .strb(strb)
);

// File: tb/test_sof_frame_sched.sv
`timescale 1ns/1ps
module test_sof_frame_sched;
  localparam int FrameBits = 64;
  localparam int CntW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b1;
  logic [CntW-1:0] guardBits = '0;
  logic swSofReq = 0, swClearBusy = 0, busReset = 0, suspend = 0, disconnect = 0;
  logic tokReq = 0, txGrant = 1, txBusy = 0, frameSet = 0, errClear = 0;
  logic [10:0] frameSetVal = '0;
  logic tokReject, launchDone, txReq, txIsSof, sofBusy, guardActive, lostSof;
  logic [10:0] txFrame;

  always #5 clk = ~clk;

  sof_frame_sched #(.FRAME_BITS(FrameBits)) i_sof_frame_sched (
    .clk, .rstN, .bitTick, .guardBits, .swSofReq, .swClearBusy, .busReset,
    .suspend, .disconnect, .tokReq, .tokReject, .launchDone, .txReq, .txIsSof,
    .txGrant, .txBusy, .txFrame, .frameSet, .frameSetVal, .sofBusy,
    .guardActive, .lostSof, .errClear
  );

  int checks = 0, failures = 0;
  int tickDiv = 1, tickCnt = 0;
  int cyc = 0, manSof = 0, autoSof = 0, tokGrants = 0, doneCnt = 0, rejCnt = 0;
  int lastSofCyc = 0, lastPeriod = 0, tokCycLast = 0, guardRun = 0, lastWin = 0;

  // bit tick generator: one pulse every tickDiv cycles
  always @(posedge clk) begin
    #1;
    if (tickCnt >= tickDiv - 1) begin tickCnt = 0; bitTick = 1'b1; end
    else begin tickCnt = tickCnt + 1; bitTick = 1'b0; end
  end

  // port monitor, sampled between edges
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (guardActive) guardRun = guardRun + 1;
    if (launchDone) doneCnt = doneCnt + 1;
    if (tokReject) rejCnt = rejCnt + 1;
    if (txReq && txGrant) begin
      if (txIsSof) begin
        if (launchDone) manSof = manSof + 1; else autoSof = autoSof + 1;
        lastPeriod = cyc - lastSofCyc;
        lastSofCyc = cyc;
        lastWin = guardRun;
        guardRun = 0;
      end else begin
        tokGrants = tokGrants + 1;
        tokCycLast = cyc;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // 0 sof, 1 clear, 2 bus reset, 3 suspend, 4 disconnect, 5 token, 6 frameSet, 7 errClear
  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: swSofReq = 1; 1: swClearBusy = 1; 2: busReset = 1; 3: suspend = 1;
      4: disconnect = 1; 5: tokReq = 1; 6: frameSet = 1; default: errClear = 1;
    endcase
    @(posedge clk); #1;
    {swSofReq, swClearBusy, busReset, suspend, disconnect, tokReq, frameSet, errClear} = '0;
  endtask

  task automatic waitAuto(input int n);
    int target = autoSof + n;
    for (int i = 0; i < 5000 && autoSof < target; i++) @(negedge clk);
    waitCyc(2);
  endtask

  task automatic waitGuard(input logic level);
    for (int i = 0; i < 5000 && guardActive != level; i++) @(negedge clk);
  endtask

  // guard, tick divider, expected period (cycles), expected window (cycles)
  localparam int Vec[4][4] = '{
    '{0, 1, 64, 1}, '{5, 1, 64, 6}, '{20, 2, 128, 42}, '{62, 1, 64, 63}
  };

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int a0, t0, d0, r0, f0;
    waitCyc(3);
    #3;
    // R1 reset state
    check("R1 busy at reset", sofBusy, 0);
    check("R1 txReq at reset", txReq, 0);
    check("R1 lostSof at reset", lostSof, 0);
    check("R1 frame at reset", txFrame, 0);
    check("R1 guard at reset", guardActive, 0);
    rstN = 1'b1;
    waitCyc(2);

    // R1 manual SOF
    guardBits = 4;
    pulse(0);
    waitCyc(3);
    check("R1 manual sof launched", manSof, 1);
    check("R1 launchDone", doneCnt, 1);
    check("R1 busy set", sofBusy, 1);
    check("R1 frame advanced", txFrame, 1);

    // R2 R3 R6 table of guard / tick rate
    for (int v = 0; v < 4; v++) begin
      guardBits = CntW'(Vec[v][0]);
      tickDiv = Vec[v][1];
      d0 = doneCnt;
      pulse(0);
      waitAuto(3);
      check("R2 sof period", lastPeriod, Vec[v][2]);
      check("R6 guard window", lastWin, Vec[v][3]);
      check("R3 auto sof silent", doneCnt, d0 + 1);
    end
    tickDiv = 1;

    // R11 wrap
    guardBits = 20;
    frameSetVal = 11'd2047;
    pulse(6);
    waitAuto(1);
    check("R11 frame wrap", txFrame, 0);

    // R7 token outside guard
    waitCyc(5);
    t0 = tokGrants; d0 = doneCnt;
    pulse(5);
    waitCyc(2);
    check("R7 token launched", tokGrants, t0 + 1);
    check("R7 launchDone", doneCnt, d0 + 1);

    // R8 token inside guard deferred
    waitGuard(1'b1);
    t0 = tokGrants;
    pulse(5);
    waitCyc(2);
    check("R8 token held", tokGrants, t0);
    waitAuto(1);
    waitCyc(2);
    check("R8 token after sof", tokGrants, t0 + 1);
    check("R8 token follows sof", tokCycLast, lastSofCyc + 1);

    // R9 second request refused
    waitGuard(1'b1);
    t0 = tokGrants; r0 = rejCnt;
    pulse(5);
    pulse(5);
    check("R9 reject pulse", rejCnt, r0 + 1);
    waitAuto(1);
    waitCyc(5);
    check("R9 single launch", tokGrants, t0 + 1);

    // R10 lost SOF
    waitGuard(1'b1);
    a0 = autoSof; f0 = txFrame;
    txBusy = 1'b1;
    waitGuard(1'b0);
    waitCyc(2);
    txBusy = 1'b0;
    waitCyc(1);
    check("R10 lost flag", lostSof, 1);
    check("R10 sof dropped", autoSof, a0);
    check("R10 frame held", txFrame, f0);
    waitAuto(1);
    check("R10 flag sticky", lostSof, 1);
    pulse(7);
    waitCyc(1);
    check("R10 flag cleared", lostSof, 0);

    // R4 R5 stop sources
    for (int k = 1; k <= 4; k++) begin
      pulse(0);
      waitAuto(1);
      pulse(k);
      waitCyc(1);
      check("R4 stop clears busy", sofBusy, 0);
      a0 = autoSof;
      waitCyc(200);
      check("R5 no auto after stop", autoSof, a0);
    end
    pulse(0);
    waitAuto(1);
    check("R5 auto resumes", autoSof, a0 + 1);
    check("R5 busy again", sofBusy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule